// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block is a register-access slave that lets an asynchronous host processor bus reach a small bank of configuration registers inside a core clock domain. A static mode pin picks one of two bus styles. With the mode pin low, the host uses separate active-low read and write strobes and waits for a ready output to go high. With the mode pin high, the host uses one active-low data strobe plus a read/write direction line, and waits for an active-low acknowledge to fall.

Chip select and both strobe pins pass through multi-flop synchronisers before an access state machine looks at them. Once a request is seen, the machine latches address and write data and counts a fixed number of core clocks. It then performs the register write, or captures the read data, and raises the handshake. Writes and reads have separate latencies. The handshake stays up until the host drops its strobe, and then the machine goes back to idle. Read data is enabled onto the bus only while the host is actually reading.

Top module: `hbi_host_port`

## Requirements
- R1: With `mode_sel`=0, a write access (`cs_n`=0, `wr_n`=0, `rd_n`=1) raises `rdy` on the WR_LAT-th rising clock edge, counting the first edge that samples the strobe as edge 1. The register at `addr` then holds `data_in`.
- R2: With `mode_sel`=0, a read access (`cs_n`=0, `rd_n`=0, `wr_n`=1) raises `rdy` on the RD_LAT-th rising edge, counted the same way. `data_out` then holds the register at `addr`.
- R3: With `mode_sel`=1, `rd_n` is the data strobe and `wr_n` is the direction line (1 = read, 0 = write). `dtack_n` falls on the WR_LAT-th edge for a write and on the RD_LAT-th edge for a read, and the register effects are as in R1 and R2.
- R4: The handshake holds for as long as the strobe is held. It is withdrawn on the (SYNC_STAGES+1)-th rising edge after the host releases the strobe.
- R5: A strobe that arrives while `cs_n`=1 starts no access. No handshake appears and no register changes.
- R6: `data_oe` is 1 only for a read whose handshake is asserted while `cs_n`=0 and the read strobe is still low. It drops in the same cycle the strobe is released, and it stays 0 for writes.
- R7: Addresses at or above NREG are unmapped. Writes to them change nothing, and reads from them return 0 with the normal handshake timing.
- R8: After reset, every register reads 0, `rdy`=0, `dtack_n`=1 and `data_oe`=0.
- R9: The handshake output of the style that is not selected stays inactive: `rdy` stays 0 while `mode_sel`=1, and `dtack_n` stays 1 while `mode_sel`=0.
- R10: With `mode_sel`=0, asserting `rd_n` and `wr_n` together is not a valid request. It produces no handshake and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Bus style: 0 = read/write strobes with ready, 1 = data strobe with direction and acknowledge |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| wr_n | input | 1 | Write strobe (mode 0, active low) or direction (mode 1, 1 = read) |
| addr | input | AW | Register address |
| data_in | input | DW | Host write data |
| data_out | output | DW | Read data |
| data_oe | output | 1 | Read data enable for the host data bus |
| rdy | output | 1 | Ready, high when an access completes in mode 0 |
| dtack_n | output | 1 | Acknowledge, low when an access completes in mode 1 |

## Verification
The hardest situation to bring about is an exact handshake edge on every access. The latency is set by the synchroniser depth plus a preloaded counter, so an off-by-one error only shows when each clock edge is sampled from the moment the strobe is applied. The bench applies strobes on the falling clock edge and compares the handshake after every rising edge, both during the wait and during the release. It does this across a full sweep of addresses in both bus styles, and the sweep includes the unmapped range. Invalid requests (a strobe without chip select, or both mode-0 strobes at once) are held for many cycles. Their harmlessness is then shown by reading the target register back through a normal access.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_DONE = 2'd2
   } hbi_state_e;

   localparam logic MODE_STROBE_RDY = 1'b0;
   localparam logic MODE_DS_ACK     = 1'b1;

endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
   parameter int              W       = 3,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbi_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/hbi_access_fsm.sv
module hbi_access_fsm
   import hbi_pkg::*;
#(
   parameter int WR_LAT      = 5,
   parameter int RD_LAT      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode,
   input  logic       cs_act,
   input  logic       rd_ln_act,
   input  logic       wr_ln_act,
   output hbi_state_e state,
   output logic       acc_read,
   output logic       start,
   output logic       commit
);

   localparam int MAX_LAT = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
   localparam int CW      = $clog2(MAX_LAT + 1);
   localparam logic [CW-1:0] WR_LOAD = CW'(WR_LAT - SYNC_STAGES - 2);
   localparam logic [CW-1:0] RD_LOAD = CW'(RD_LAT - SYNC_STAGES - 2);

   logic          req_ok;
   logic          req_rd;
   logic          released;
   logic [CW-1:0] cnt;

   always_comb begin
      if (mode == MODE_STROBE_RDY) begin
         req_ok   = cs_act && (rd_ln_act ^ wr_ln_act);
         req_rd   = rd_ln_act;
         released = !(rd_ln_act || wr_ln_act);
      end else begin
         req_ok   = cs_act && rd_ln_act;
         req_rd   = !wr_ln_act;
         released = !rd_ln_act;
      end
   end

   assign start  = (state == ST_IDLE) && req_ok;
   assign commit = (state == ST_WAIT) && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         acc_read <= 1'b0;
         cnt      <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req_ok) begin
                  state    <= ST_WAIT;
                  acc_read <= req_rd;
                  cnt      <= req_rd ? RD_LOAD : WR_LOAD;
               end
            end
            ST_WAIT: begin
               if (cnt == '0) state <= ST_DONE;
               else           cnt   <= cnt - 1'b1;
            end
            ST_DONE: begin
               if (released) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/hbi_regfile.sv
module hbi_regfile #(
   parameter int AW   = 4,
   parameter int DW   = 16,
   parameter int NREG = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   generate
      if (NREG < 1 || NREG > (1 << AW)) begin : g_bad_nreg
         $error("hbi_regfile: NREG must lie in 1 .. 2**AW");
      end
   endgenerate

   logic [DW-1:0] regs [NREG];
   logic          r_hit;

   generate
      if (NREG == (1 << AW)) begin : g_full_map
         assign r_hit = 1'b1;
      end else begin : g_part_map
         assign r_hit = (raddr < AW'(NREG));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (we) begin
         for (int i = 0; i < NREG; i++)
            if (waddr == AW'(i)) regs[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (r_hit) begin
         for (int i = 0; i < NREG; i++)
            if (raddr == AW'(i)) rdata = regs[i];
      end
   end

endmodule

// File: rtl/hbi_host_port.sv
module hbi_host_port
   import hbi_pkg::*;
#(
   parameter int AW          = 4,
   parameter int DW          = 16,
   parameter int NREG        = 12,
   parameter int SYNC_STAGES = 2,
   parameter int WR_LAT      = 5,
   parameter int RD_LAT      = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_sel,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data_in,
   output logic [DW-1:0] data_out,
   output logic          data_oe,
   output logic          rdy,
   output logic          dtack_n
);

   generate
      if (WR_LAT < 4 || WR_LAT > 9) begin : g_bad_wr
         $error("hbi_host_port: WR_LAT must lie in 4 .. 9");
      end
      if (RD_LAT < 8 || RD_LAT > 13) begin : g_bad_rd
         $error("hbi_host_port: RD_LAT must lie in 8 .. 13");
      end
      if (WR_LAT < SYNC_STAGES + 2) begin : g_bad_sync
         $error("hbi_host_port: WR_LAT too short for SYNC_STAGES");
      end
   endgenerate

   logic [2:0]    ctl_s;
   hbi_state_e    state;
   logic          acc_read;
   logic          start;
   logic          commit;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic [DW-1:0] rdata;
   logic          rd_strobe_now;

   hbi_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b111)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, rd_n, wr_n}),
      .q     (ctl_s)
   );

   hbi_access_fsm #(
      .WR_LAT      (WR_LAT),
      .RD_LAT      (RD_LAT),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_sel),
      .cs_act    (!ctl_s[2]),
      .rd_ln_act (!ctl_s[1]),
      .wr_ln_act (!ctl_s[0]),
      .state     (state),
      .acc_read  (acc_read),
      .start     (start),
      .commit    (commit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (start) begin
         addr_q  <= addr;
         wdata_q <= data_in;
      end
   end

   hbi_regfile #(
      .AW   (AW),
      .DW   (DW),
      .NREG (NREG)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (commit && !acc_read),
      .waddr (addr_q),
      .wdata (wdata_q),
      .raddr (addr_q),
      .rdata (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  data_out <= '0;
      else if (commit && acc_read) data_out <= rdata;
   end

   assign rd_strobe_now = !cs_n && !rd_n &&
                          ((mode_sel == MODE_DS_ACK) ? wr_n : 1'b1);
   assign data_oe = (state == ST_DONE) && acc_read && rd_strobe_now;
   assign rdy     = (mode_sel == MODE_STROBE_RDY) && (state == ST_DONE);
   assign dtack_n = !((mode_sel == MODE_DS_ACK) && (state == ST_DONE));

endmodule

// File: rtl/hbi_host_port_chk.sv
module hbi_host_port_chk #(
   parameter int WR_LAT = 5,
   parameter int RD_LAT = 10
) (
   input logic clk,
   input logic rst_n,
   input logic mode_sel,
   input logic cs_n,
   input logic rd_n,
   input logic wr_n,
   input logic data_oe,
   input logic rdy,
   input logic dtack_n
);

   logic       hs_on;
   logic       strobe_on;
   logic [5:0] str_cnt;

   assign hs_on     = mode_sel ? !dtack_n : rdy;
   assign strobe_on = !cs_n && (mode_sel ? !rd_n : (!rd_n || !wr_n));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               str_cnt <= '0;
      else if (!strobe_on)      str_cnt <= '0;
      else if (str_cnt != '1)   str_cnt <= str_cnt + 1'b1;
   end

   // R1, R2, R3, R5
   hs_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_on) |-> (str_cnt == 6'(WR_LAT) || str_cnt == 6'(RD_LAT)));

   // R6
   oe_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (rdy || !dtack_n));

   // R6
   oe_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (!cs_n && !rd_n));

   // R9
   rdy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdy |-> !mode_sel);

   // R9
   dtack_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dtack_n |-> mode_sel);

endmodule

bind hbi_host_port hbi_host_port_chk #(
   .WR_LAT (WR_LAT),
   .RD_LAT (RD_LAT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_sel (mode_sel),
   .cs_n     (cs_n),
   .rd_n     (rd_n),
   .wr_n     (wr_n),
   .data_oe  (data_oe),
   .rdy      (rdy),
   .dtack_n  (dtack_n)
);

// File: tb/hbi_host_port_test.sv
module hbi_host_port_test;

   localparam int AW = 4;
   localparam int DW = 16;
   localparam int NREG = 12;
   localparam int SYNC_STAGES = 2;
   localparam int WR_LAT = 5;
   localparam int RD_LAT = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_sel = 1'b0;
   logic          cs_n = 1'b1;
   logic          rd_n = 1'b1;
   logic          wr_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] data_in = '0;
   logic [DW-1:0] data_out;
   logic          data_oe;
   logic          rdy;
   logic          dtack_n;

   int errors = 0;
   int checks = 0;
   logic [DW-1:0] model [1 << AW];

   always #5 clk = ~clk;

   hbi_host_port #(
      .AW(AW), .DW(DW), .NREG(NREG), .SYNC_STAGES(SYNC_STAGES),
      .WR_LAT(WR_LAT), .RD_LAT(RD_LAT)
   ) uut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
      .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .data_in(data_in),
      .data_out(data_out), .data_oe(data_oe), .rdy(rdy), .dtack_n(dtack_n)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic hs_of(input logic m);
      return m ? !dtack_n : rdy;
   endfunction

   function automatic logic other_hs(input logic m);
      return m ? rdy : !dtack_n;
   endfunction

   task automatic access(input logic m, input logic rd, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, output logic [DW-1:0] rv);
      int    lat;
      int    bad_k;
      bit    other_bad;
      string lreq;
      lat = rd ? RD_LAT : WR_LAT;
      lreq = m ? "R3" : (rd ? "R2" : "R1");
      bad_k = 0;
      other_bad = 0;
      @(negedge clk);
      mode_sel = m; addr = a; data_in = wd; cs_n = 1'b0;
      rd_n = m ? 1'b0 : !rd;
      wr_n = rd;
      for (int k = 1; k <= lat; k++) begin
         @(posedge clk); #1;
         if (bad_k == 0 && hs_of(m) !== (k == lat)) bad_k = k;
         if (other_hs(m)) other_bad = 1;
      end
      check(bad_k == 0, lreq, bad_k, 0);
      check(data_oe == rd, "R6", data_oe, rd);
      rv = data_out;
      for (int k = 0; k < 2; k++) begin
         @(posedge clk); #1;
         check(hs_of(m) == 1'b1, "R4", hs_of(m), 1);
         if (other_hs(m)) other_bad = 1;
      end
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
      #1;
      check(data_oe == 1'b0, "R6", data_oe, 0);
      bad_k = 0;
      for (int k = 1; k <= SYNC_STAGES + 1; k++) begin
         @(posedge clk); #1;
         if (bad_k == 0 && hs_of(m) !== (k <= SYNC_STAGES)) bad_k = k;
         if (other_hs(m)) other_bad = 1;
      end
      check(bad_k == 0, "R4", bad_k, 0);
      check(!other_bad, "R9", other_bad, 0);
      repeat (2) @(posedge clk);
   endtask

   task automatic sweep_write(input logic m, input logic [DW-1:0] seed);
      logic [DW-1:0] v;
      logic [DW-1:0] dummy;
      for (int a = 0; a < (1 << AW); a++) begin
         v = seed ^ DW'(a * 16'h0111);
         access(m, 1'b0, AW'(a), v, dummy);
         if (a < NREG) model[a] = v;
      end
   endtask

   task automatic sweep_read(input logic m, input string req);
      logic [DW-1:0] rv;
      for (int a = 0; a < (1 << AW); a++) begin
         access(m, 1'b1, AW'(a), '0, rv);
         if (a >= NREG) check(rv == '0, "R7", rv, 0);
         else           check(rv == model[a], req, rv, model[a]);
      end
   endtask

   task automatic hold_invalid(input logic c, input logic r, input logic w, input string req);
      bit seen;
      seen = 0;
      @(negedge clk);
      mode_sel = 1'b0; addr = 4'd3; data_in = 16'hDEAD;
      cs_n = c; rd_n = r; wr_n = w;
      repeat (20) begin
         @(posedge clk); #1;
         if (rdy || !dtack_n || data_oe) seen = 1;
      end
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
      repeat (4) @(posedge clk);
      check(!seen, req, seen, 0);
   endtask

   initial begin
      logic [DW-1:0] rv;
      for (int a = 0; a < (1 << AW); a++) model[a] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      check(rdy == 1'b0 && dtack_n == 1'b1 && data_oe == 1'b0, "R8",
            {rdy, dtack_n, data_oe}, 3'b010);
      // R8: every register reads zero after reset
      sweep_read(1'b0, "R8");
      sweep_write(1'b0, 16'hA500);
      sweep_read(1'b0, "R2");
      sweep_read(1'b1, "R3");
      sweep_write(1'b1, 16'h3C5A);
      sweep_read(1'b1, "R3");
      sweep_read(1'b0, "R1");
      // R5: write strobe with no chip select
      hold_invalid(1'b1, 1'b1, 1'b0, "R5");
      access(1'b0, 1'b1, 4'd3, '0, rv);
      check(rv == model[3], "R5", rv, model[3]);
      // R10: both mode-0 strobes together
      hold_invalid(1'b0, 1'b0, 1'b0, "R10");
      access(1'b0, 1'b1, 4'd3, '0, rv);
      check(rv == model[3], "R10", rv, model[3]);
      // R7: unmapped write then mapped neighbour unchanged
      access(1'b1, 1'b0, 4'd15, 16'hFFFF, rv);
      access(1'b1, 1'b1, 4'd15, '0, rv);
      check(rv == '0, "R7", rv, 0);
      access(1'b0, 1'b1, 4'd11, '0, rv);
      check(rv == model[11], "R7", rv, model[11]);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule